// File: doc/BRIEF.md
# Banked Byte-Lane Memory Select and Wait-State Unit

This block sits between a synchronous processor-style bus and a module of byte-wide static RAM devices arranged in rows. Each row spans every byte lane of the data path, and each lane of a row is one byte-wide device. The unit compares the upper address bits with a base address fixed by parameter. On a match it raises exactly one row select and passes the word-address bits below the row field to the devices as `dev_addr`.

Read and write requests are level strobes held by the requester until `ready` is seen high. A read turns on the output enable of every lane of the selected row. The requester then takes the byte or bytes it wants from the full-width data. A write pulses the write strobe of only the lanes whose active-low byte enable is 0, so untouched bytes keep their old contents.

`ready` is held low for a parameter number of wait cycles so that slow devices meet their access time. Write strobes are issued only in the completion cycle. A parameter chooses two lanes (16-bit data) or four lanes (32-bit data). A second parameter chooses full decoding, or a partial decode that leaves low-order tag bits uncompared so that the module repeats through the address map.

Top module: `mem_lane_decoder`

## Requirements
- R1: An access (exactly one of `rd`/`wr` high) whose address tag equals the base tag raises the single `dev_sel` bit given by the row field directly above the device address bits. With defaults (base C0000h, 2 lanes, 16K words per row) rows start at C0000h, C8000h, D0000h and D8000h.
- R2: An access whose tag does not match raises no `dev_sel`, no `lane_oe` and no `lane_we`, and `ready` is high in its first cycle.
- R3: With full decode off, only the top `PARTIAL_W` tag bits are compared, so with one bit compared the module also answers at E0000h. An address with bit 19 clear still misses.
- R4: During a decoded read, every bit of `lane_oe` is 1 in every cycle of the access, whatever `byte_en_n` holds, and `lane_we` stays 0.
- R5: During a decoded write, `lane_we[i]` is 1 only in the cycle where `ready` is 1, and only where `byte_en_n[i]` is 0. With two lanes, bit 0 is A0 (low bank, even bytes, data 7..0) and bit 1 is the active-low bus-high-enable (high bank, odd bytes, data 15..8). `lane_oe` stays 0.
- R6: `ready` is 0 for exactly `WAIT_STATES` cycles starting in the first cycle of a decoded access, and is 1 after that while the strobe is held. With `WAIT_STATES` of 0 it never drops.
- R7: When `rd` and `wr` are both high, nothing is selected, no strobe is issued and `ready` stays 1.
- R8: With four lanes, `word_addr` starts at bit 2, `byte_en_n` has four bits (bit i gates the write strobe of lane i), and reads enable all four lanes.
- R9: After reset with idle inputs, `ready` is 1 and `dev_sel`, `lane_oe` and `lane_we` are 0.
- R10: At most one bit of `dev_sel` is 1 in any cycle.
- R11: `dev_addr` equals the `DEV_AW` word-address bits just below the row field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_addr | input | ADDR_W-LSB_W | Bus address without the byte-offset bits |
| byte_en_n | input | LANES | Active-low lane enables (lane 0 is A0 with two lanes) |
| rd | input | 1 | Read strobe, held until ready |
| wr | input | 1 | Write strobe, held until ready |
| dev_sel | output | 2**ROW_W | One-hot device row select |
| dev_addr | output | DEV_AW | Address within a device |
| lane_oe | output | LANES | Per-lane output enable |
| lane_we | output | LANES | Per-lane write strobe |
| ready | output | 1 | Low while wait states are inserted |

## Verification
The write strobe and the end of the wait period are tied to the same cycle, because a lane may only be written once `ready` has risen. The bench holds each write request and samples the outputs one nanosecond before every rising edge. It requires `lane_we` to be 0 in every cycle where `ready` is 0, and equal to the expected lane pattern in the first cycle where `ready` is 1. It also counts the low cycles against the wait-state parameter. A zero-wait instance provokes the case where the chip select, the strobe and the ready cycle all fall in the first cycle of the access.

// File: rtl/mld_pkg.sv
package mld_pkg;

  typedef enum logic [1:0] {
    OP_IDLE     = 2'b00,
    OP_READ     = 2'b01,
    OP_WRITE    = 2'b10,
    OP_CONFLICT = 2'b11
  } bus_op_e;

  // number of byte-offset address bits for a given lane count
  function automatic int lane_bits(input int lanes);
    return (lanes == 4) ? 2 : 1;
  endfunction

  function automatic bus_op_e classify(input logic rd, input logic wr);
    return bus_op_e'({wr, rd});
  endfunction

endpackage

// File: rtl/mld_addr_match.sv
module mld_addr_match #(
  parameter int MATCH_W     = 3,
  parameter int FULL_DECODE = 1,
  parameter int PARTIAL_W   = 1,
  parameter logic [MATCH_W-1:0] BASE_TAG = '0
) (
  input  logic [MATCH_W-1:0] tag,
  output logic               hit
);
  localparam int CMP_W = (FULL_DECODE != 0) ? MATCH_W : PARTIAL_W;

  // compare only the upper CMP_W tag bits; lower ones are left open
  generate
    if (CMP_W >= MATCH_W) begin : g_full
      assign hit = (tag == BASE_TAG);
    end else begin : g_part
      assign hit = (tag[MATCH_W-1 -: CMP_W] == BASE_TAG[MATCH_W-1 -: CMP_W]);
    end
  endgenerate

endmodule

// File: rtl/mld_row_dec.sv
module mld_row_dec #(
  parameter int ROW_W = 2,
  localparam int NUM_DEV = 1 << ROW_W
) (
  input  logic               en,
  input  logic [ROW_W-1:0]   row,
  output logic [NUM_DEV-1:0] sel
);
  genvar g;
  generate
    for (g = 0; g < NUM_DEV; g++) begin : g_row
      assign sel[g] = en && (row == ROW_W'(g));
    end
  endgenerate
endmodule

// File: rtl/mld_lane_ctl.sv
module mld_lane_ctl #(
  parameter int LANES = 2
) (
  input  logic             do_read,
  input  logic             do_write,
  input  logic             ready,
  input  logic [LANES-1:0] byte_en_n,
  output logic [LANES-1:0] lane_oe,
  output logic [LANES-1:0] lane_we
);
  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      // reads open every lane; the requester picks its bytes
      assign lane_oe[g] = do_read;
      // writes touch only enabled lanes, and only on the completion cycle
      assign lane_we[g] = do_write && ready && !byte_en_n[g];
    end
  endgenerate
endmodule

// File: rtl/mld_wait_timer.sv
module mld_wait_timer #(
  parameter int WAIT_STATES = 2,
  localparam int CNT_W = (WAIT_STATES > 0) ? $clog2(WAIT_STATES + 1) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic ready
);
  logic [1:0]       rst_sync_q;
  logic             run_en;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_done;

  // reset asserted at once, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign run_en = rst_sync_q[1];

  assign cnt_done = (cnt_q == CNT_W'(WAIT_STATES));

  always_comb begin
    if (!active)       cnt_d = '0;
    else if (cnt_done) cnt_d = cnt_q;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (run_en) cnt_q <= cnt_d;
  end

  assign ready = !active || cnt_done;

endmodule

// File: rtl/mem_lane_decoder.sv
module mem_lane_decoder
  import mld_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int LANES       = 2,
  parameter int DEV_AW      = 14,
  parameter int ROW_W       = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'hC0000,
  parameter int FULL_DECODE = 1,
  parameter int PARTIAL_W   = 1,
  parameter int WAIT_STATES = 2,
  localparam int LSB_W   = lane_bits(LANES),
  localparam int NUM_DEV = 1 << ROW_W,
  localparam int ROW_LO  = LSB_W + DEV_AW,
  localparam int TAG_LO  = ROW_LO + ROW_W,
  localparam int MATCH_W = ADDR_W - TAG_LO
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:LSB_W]   word_addr,
  input  logic [LANES-1:0]        byte_en_n,
  input  logic                    rd,
  input  logic                    wr,
  output logic [NUM_DEV-1:0]      dev_sel,
  output logic [DEV_AW-1:0]       dev_addr,
  output logic [LANES-1:0]        lane_oe,
  output logic [LANES-1:0]        lane_we,
  output logic                    ready
);
  localparam logic [MATCH_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:TAG_LO];

  bus_op_e op;
  logic    hit;
  logic    active;
  logic    do_read;
  logic    do_write;

  assign op       = classify(rd, wr);
  assign active   = hit && (op == OP_READ || op == OP_WRITE);
  assign do_read  = hit && (op == OP_READ);
  assign do_write = hit && (op == OP_WRITE);
  assign dev_addr = word_addr[LSB_W +: DEV_AW];

  mld_addr_match #(
    .MATCH_W    (MATCH_W),
    .FULL_DECODE(FULL_DECODE),
    .PARTIAL_W  (PARTIAL_W),
    .BASE_TAG   (BASE_TAG)
  ) u_match (
    .tag(word_addr[ADDR_W-1:TAG_LO]),
    .hit(hit)
  );

  mld_row_dec #(.ROW_W(ROW_W)) u_rows (
    .en (active),
    .row(word_addr[ROW_LO +: ROW_W]),
    .sel(dev_sel)
  );

  mld_wait_timer #(.WAIT_STATES(WAIT_STATES)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .active(active),
    .ready (ready)
  );

  mld_lane_ctl #(.LANES(LANES)) u_lanes (
    .do_read  (do_read),
    .do_write (do_write),
    .ready    (ready),
    .byte_en_n(byte_en_n),
    .lane_oe  (lane_oe),
    .lane_we  (lane_we)
  );

endmodule

// File: rtl/mld_checker.sv
module mld_checker #(
  parameter int LANES       = 2,
  parameter int NUM_DEV     = 4,
  parameter int WAIT_STATES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd,
  input logic               wr,
  input logic [LANES-1:0]   byte_en_n,
  input logic [NUM_DEV-1:0] dev_sel,
  input logic [LANES-1:0]   lane_oe,
  input logic [LANES-1:0]   lane_we,
  input logic               ready
);
  logic [7:0] low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_run_q <= '0;
    else if (ready)     low_run_q <= '0;
    else if (low_run_q != 8'hFF) low_run_q <= low_run_q + 8'd1;
  end

  // R10
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel));

  // R2
  miss_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_sel == '0) |-> (ready && lane_we == '0 && lane_oe == '0));

  // R4
  read_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !wr && dev_sel != '0) |-> (lane_oe == {LANES{1'b1}} && lane_we == '0));

  // R5
  write_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_we != '0) |-> (ready && wr && (lane_we & ~byte_en_n) == lane_we));

  // R6
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (int'(low_run_q) < WAIT_STATES));

  // R6
  wait_first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((WAIT_STATES > 0) && dev_sel != '0 && $past(dev_sel) == '0) |-> !ready);

  // R7
  conflict_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && wr) |-> (dev_sel == '0 && ready));

endmodule

bind mem_lane_decoder mld_checker #(
  .LANES      (LANES),
  .NUM_DEV    (NUM_DEV),
  .WAIT_STATES(WAIT_STATES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd       (rd),
  .wr       (wr),
  .byte_en_n(byte_en_n),
  .dev_sel  (dev_sel),
  .lane_oe  (lane_oe),
  .lane_we  (lane_we),
  .ready    (ready)
);

// File: tb/mem_lane_decoder_tb.sv
`timescale 1ns/1ps
module mem_lane_decoder_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  // default two-lane instance and a partial-decode, zero-wait twin
  logic [19:1] addr;
  logic [1:0]  be_n;
  logic        rd, wr;
  logic [3:0]  sel, m_sel;
  logic [13:0] daddr, m_daddr;
  logic [1:0]  oe, we, m_oe, m_we;
  logic        rdy, m_rdy;

  // four-lane instance
  logic [19:2] w_addr;
  logic [3:0]  w_be_n;
  logic        w_rd, w_wr;
  logic [3:0]  w_sel, w_oe, w_we;
  logic [12:0] w_daddr;
  logic        w_rdy;

  mem_lane_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .word_addr(addr), .byte_en_n(be_n),
    .rd(rd), .wr(wr), .dev_sel(sel), .dev_addr(daddr),
    .lane_oe(oe), .lane_we(we), .ready(rdy));

  mem_lane_decoder #(.FULL_DECODE(0), .PARTIAL_W(1), .WAIT_STATES(0)) u_mirror (
    .clk(clk), .rst_n(rst_n), .word_addr(addr), .byte_en_n(be_n),
    .rd(rd), .wr(wr), .dev_sel(m_sel), .dev_addr(m_daddr),
    .lane_oe(m_oe), .lane_we(m_we), .ready(m_rdy));

  mem_lane_decoder #(.LANES(4), .DEV_AW(13)) u_wide (
    .clk(clk), .rst_n(rst_n), .word_addr(w_addr), .byte_en_n(w_be_n),
    .rd(w_rd), .wr(w_wr), .dev_sel(w_sel), .dev_addr(w_daddr),
    .lane_oe(w_oe), .lane_we(w_we), .ready(w_rdy));

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic        rd;
    logic        wr;
    logic [19:0] a;
    logic [1:0]  be;
    logic [3:0]  sel;
    logic [1:0]  oe;
    logic [1:0]  we;
    logic [3:0]  wt;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 20'hC0000, 2'b00, 4'b0001, 2'b11, 2'b00, 4'd2},
    '{1'b1, 1'b0, 20'hC8001, 2'b01, 4'b0010, 2'b11, 2'b00, 4'd2},
    '{1'b0, 1'b1, 20'hD0000, 2'b10, 4'b0100, 2'b00, 2'b01, 4'd2},
    '{1'b0, 1'b1, 20'hD8001, 2'b01, 4'b1000, 2'b00, 2'b10, 4'd2},
    '{1'b0, 1'b1, 20'hDFFFE, 2'b00, 4'b1000, 2'b00, 2'b11, 4'd2},
    '{1'b0, 1'b1, 20'hC7FFF, 2'b01, 4'b0001, 2'b00, 2'b10, 4'd2},
    '{1'b1, 1'b0, 20'hE0000, 2'b00, 4'b0000, 2'b00, 2'b00, 4'd0},
    '{1'b0, 1'b1, 20'hBFFFE, 2'b00, 4'b0000, 2'b00, 2'b00, 4'd0},
    '{1'b1, 1'b1, 20'hC0000, 2'b00, 4'b0000, 2'b00, 2'b00, 4'd0},
    '{1'b0, 1'b1, 20'hC0000, 2'b11, 4'b0001, 2'b00, 2'b00, 4'd2}
  };

  task automatic idle_all();
    rd = 0; wr = 0; addr = '0; be_n = 2'b11;
    w_rd = 0; w_wr = 0; w_addr = '0; w_be_n = 4'hF;
  endtask

  // drive one request on the two-lane bus and follow it to completion
  task automatic run_vec(input int i);
    vec_t v;
    int waits;
    logic early_we;
    v = VECS[i];
    @(negedge clk);
    rd = v.rd; wr = v.wr; addr = v.a[19:1]; be_n = v.be;
    waits = 0; early_we = 1'b0;
    for (int k = 0; k < 20; k++) begin
      #4;
      if (rdy) break;
      if (we != 2'b00) early_we = 1'b1;
      if (sel != v.sel) early_we = 1'b1;
      waits++;
      @(negedge clk);
    end
    check("R1/R2/R7", $sformatf("vec%0d dev_sel", i), sel, v.sel);
    check("R4", $sformatf("vec%0d lane_oe", i), oe, v.oe);
    check("R5", $sformatf("vec%0d lane_we", i), we, v.we);
    check("R6", $sformatf("vec%0d wait cycles", i), waits, v.wt);
    check("R5", $sformatf("vec%0d no strobe before ready", i), early_we, 1'b0);
    @(negedge clk);
    idle_all();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle_all();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #4;
    // R9 idle state after reset
    check("R9", "ready", rdy, 1'b1);
    check("R9", "dev_sel", sel, 4'b0000);
    check("R9", "lane_oe/we", {oe, we}, 4'b0000);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R11 device address slice: C7FFFh -> word 63FFFh -> low 14 bits 3FFFh
    @(negedge clk);
    rd = 1; addr = 19'h63FFF; be_n = 2'b01;
    #4;
    check("R11", "dev_addr", daddr, 14'h3FFF);
    check("R6", "first cycle ready low", rdy, 1'b0);
    @(negedge clk); #4;
    check("R4", "lane_oe mid-wait", oe, 2'b11);
    @(negedge clk); #4;
    check("R6", "ready after two waits", rdy, 1'b1);
    @(negedge clk); #4;
    check("R6", "ready held while strobe held", rdy, 1'b1);
    @(negedge clk); idle_all();

    // R3 partial decode mirrors at E0000h, zero wait
    @(negedge clk);
    rd = 1; addr = 19'h70000; be_n = 2'b00;
    #4;
    check("R3", "full-decode instance misses E0000", sel, 4'b0000);
    check("R3", "mirror selects row0 at E0000", m_sel, 4'b0001);
    check("R6", "zero-wait ready", m_rdy, 1'b1);
    @(negedge clk); idle_all();
    @(negedge clk);
    wr = 1; addr = 19'h70001; be_n = 2'b10;
    #4;
    check("R5", "zero-wait low-lane write", m_we, 2'b01);
    @(negedge clk); idle_all();
    @(negedge clk);
    rd = 1; addr = 19'h20000;
    #4;
    check("R3", "mirror misses 40000", m_sel, 4'b0000);
    @(negedge clk); idle_all();

    // R8 four-lane instance
    @(negedge clk);
    w_wr = 1; w_addr = 18'h30001; w_be_n = 4'b1010;
    #4;
    check("R8", "wide select", w_sel, 4'b0001);
    check("R8", "wide no strobe in wait", w_we, 4'b0000);
    @(negedge clk); @(negedge clk); #4;
    check("R8", "wide ready", w_rdy, 1'b1);
    check("R8", "wide lane strobes", w_we, 4'b0101);
    @(negedge clk); idle_all();
    @(negedge clk);
    w_rd = 1; w_addr = 18'h36000; w_be_n = 4'b1110;
    #4;
    check("R8", "wide read row3", w_sel, 4'b1000);
    check("R8", "wide read lanes", w_oe, 4'b1111);
    @(negedge clk); idle_all();

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule